// File: doc/BRIEF.md
# Coarse-Instruction Issue Sequencer

This block is the control front end of an inference accelerator. A host writes 32-bit coarse instructions through a valid/ready port. They are held in an on-chip queue and carried out strictly one at a time, in the order they were written. Each instruction names one of five execution engines:

| Opcode | Engine |
|---|---|
| 0 | host-memory read |
| 1 | weight fetch |
| 2 | matrix multiply / convolution |
| 3 | activation |
| 4 | host-memory write |

The sequencer gives the chosen engine a single-cycle start pulse together with a 16-bit operand. It then waits, for as many cycles as the engine needs, until that engine reports done. Only then does it retire the instruction and move on.

The engines, the host link and external memory sit outside the block and are seen only through the start/done lines. Opcodes that name no engine are dropped and noted in a sticky error flag. A busy output tells the host whether any work is still queued or running.

Top module: `cisc_issue_seq`

## Requirements
- R1: After reset `wr_ready` is 1, `busy` is 0, `eng_start` is all zero and `bad_opc` is 0.
- R2: The queue holds 16 instructions. `wr_ready` is 0 exactly while 16 are held, and a word offered while `wr_ready` is 0 is not taken and never issues.
- R3: Instructions issue in the order they were accepted. During the start pulse, and for the whole wait, `eng_arg` carries bits [18:3] of that instruction and stays unchanged.
- R4: The opcode sits in bits [2:0]. Opcode k (0 to 4) drives `eng_start[k]`: 0 is host read, 1 is weight fetch, 2 is matrix multiply, 3 is activation, 4 is host write.
- R5: A start pulse lasts exactly one cycle, and at most one bit of `eng_start` is ever high.
- R6: No new start is issued until `eng_done[k]` is seen for the engine k in flight. A done on any other engine, or any done while nothing is in flight, has no effect.
- R7: Opcodes 5, 6 and 7 issue no start, are removed from the queue, and set `bad_opc`, which stays at 1 until reset. The instructions that follow still issue.
- R8: `busy` is 1 whenever an instruction is in flight or the queue is non-empty, and 0 otherwise.
- R9: A synchronous reset, held high for a cycle, empties the queue, abandons any instruction in flight and clears `bad_opc`.
- R10: Bits [31:19] of an instruction are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_valid | input | 1 | Host offers an instruction |
| wr_data | input | 32 | Instruction word |
| wr_ready | output | 1 | Queue can take a word |
| eng_start | output | 5 | One-cycle start pulse, one bit per engine |
| eng_arg | output | 16 | Operand of the instruction in flight |
| eng_done | input | 5 | Completion pulse, one bit per engine |
| busy | output | 1 | Work queued or in flight |
| bad_opc | output | 1 | Sticky: an unused opcode was seen |

## Verification
The assertions take for granted that an engine raises its done line only for an instruction it was started on, or as a stray pulse that must be ignored. They also assume the host holds a word steady while it is offering it.

The bench keeps to this. A responder answers each start on the started engine after a varying delay, and drops stray done pulses on a different engine during the wait, or on every engine while idle. Host words are offered only at the falling edge, and each is withdrawn once it has been accepted. The one exception is a deliberate offer while the queue is full, made to check that it is refused.

// File: rtl/cseq_pkg.sv
`timescale 1ns/1ps
package cseq_pkg;
   // engine numbering equals opcode value
   typedef enum logic [2:0] {
      OP_HOST_RD = 3'd0,
      OP_WGT_RD  = 3'd1,
      OP_MATMUL  = 3'd2,
      OP_ACT     = 3'd3,
      OP_HOST_WR = 3'd4
   } opc_e;

   typedef enum logic {
      SQ_IDLE = 1'b0,
      SQ_WAIT = 1'b1
   } sq_state_e;
endpackage

// File: rtl/cseq_fifo.sv
`timescale 1ns/1ps
module cseq_fifo #(
   parameter int unsigned W     = 19,
   parameter int unsigned DEPTH = 16
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         push,
   input  logic [W-1:0] din,
   input  logic         pop,
   output logic [W-1:0] head,
   output logic         empty,
   output logic         full
);
   localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int unsigned CNT_W = PTR_W + 1;

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("cseq_fifo: DEPTH must be a power of two of at least 2");
   end
   if (W < 1) begin : g_bad_width
      $error("cseq_fifo: W must be positive");
   end

   logic [W-1:0]     mem_q [DEPTH];
   logic [PTR_W-1:0] wp_q, rp_q;
   logic [CNT_W-1:0] cnt_q;
   logic             do_push, do_pop;

   assign empty   = (cnt_q == '0);
   assign full    = (cnt_q == CNT_W'(DEPTH));
   assign do_push = push && !full;
   assign do_pop  = pop && !empty;
   assign head    = mem_q[rp_q];

   always_ff @(posedge clk) begin
      if (do_push) mem_q[wp_q] <= din;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         wp_q  <= '0;
         rp_q  <= '0;
         cnt_q <= '0;
      end else begin
         if (do_push) wp_q <= wp_q + 1'b1;
         if (do_pop)  rp_q <= rp_q + 1'b1;
         case ({do_push, do_pop})
            2'b10:   cnt_q <= cnt_q + 1'b1;
            2'b01:   cnt_q <= cnt_q - 1'b1;
            default: cnt_q <= cnt_q;
         endcase
      end
   end

   // R2: occupancy never exceeds capacity
   a_r2_no_overflow: assert property (@(posedge clk) disable iff (rst)
      cnt_q <= CNT_W'(DEPTH));
   // R2: the sequencer never takes from an empty queue
   a_r2_no_underflow: assert property (@(posedge clk) disable iff (rst)
      pop |-> !empty);
endmodule

// File: rtl/cseq_decode.sv
`timescale 1ns/1ps
module cseq_decode #(
   parameter int unsigned OPC_W = 3,
   parameter int unsigned ARG_W = 16,
   parameter int unsigned N_ENG = 5
) (
   input  logic [OPC_W+ARG_W-1:0] word,
   output logic [N_ENG-1:0]       sel,
   output logic                   op_ok,
   output logic [ARG_W-1:0]       arg
);
   if (N_ENG > (1 << OPC_W)) begin : g_bad_eng
      $error("cseq_decode: more engines than opcode values");
   end

   logic [OPC_W-1:0] opc;
   assign opc = word[OPC_W-1:0];
   assign arg = word[OPC_W +: ARG_W];

   for (genvar e = 0; e < N_ENG; e++) begin : g_sel
      assign sel[e] = (opc == OPC_W'(e));
   end

   assign op_ok = |sel;
endmodule

// File: rtl/cseq_ctrl.sv
`timescale 1ns/1ps
module cseq_ctrl
   import cseq_pkg::*;
#(
   parameter int unsigned N_ENG = 5,
   parameter int unsigned ARG_W = 16
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             head_valid,
   input  logic             op_ok,
   input  logic [N_ENG-1:0] sel,
   input  logic [ARG_W-1:0] arg_in,
   input  logic [N_ENG-1:0] eng_done,
   output logic             pop,
   output logic [N_ENG-1:0] eng_start,
   output logic [ARG_W-1:0] eng_arg,
   output logic             bad_opc,
   output logic             in_flight
);
   sq_state_e        st_q;
   logic [N_ENG-1:0] cur_q;
   logic [N_ENG-1:0] start_q;
   logic [ARG_W-1:0] arg_q;
   logic             bad_q;
   logic             retire;

   assign pop       = (st_q == SQ_IDLE) && head_valid;
   assign retire    = (st_q == SQ_WAIT) && |(eng_done & cur_q);
   assign eng_start = start_q;
   assign eng_arg   = arg_q;
   assign bad_opc   = bad_q;
   assign in_flight = (st_q == SQ_WAIT);

   always_ff @(posedge clk) begin
      if (rst) begin
         st_q    <= SQ_IDLE;
         cur_q   <= '0;
         start_q <= '0;
         arg_q   <= '0;
         bad_q   <= 1'b0;
      end else begin
         start_q <= '0;
         case (st_q)
            SQ_IDLE: begin
               if (head_valid) begin
                  if (op_ok) begin
                     start_q <= sel;
                     cur_q   <= sel;
                     arg_q   <= arg_in;
                     st_q    <= SQ_WAIT;
                  end else begin
                     bad_q <= 1'b1;
                  end
               end
            end
            SQ_WAIT: begin
               if (retire) st_q <= SQ_IDLE;
            end
            default: st_q <= SQ_IDLE;
         endcase
      end
   end

   // R5: never more than one engine started
   a_r5_onehot: assert property (@(posedge clk) disable iff (rst)
      $onehot0(eng_start));
   // R5: start lasts a single cycle
   a_r5_pulse: assert property (@(posedge clk) disable iff (rst)
      (|eng_start) |=> (eng_start == '0));
   // R6: no new start while the current engine has not finished
   a_r6_hold_issue: assert property (@(posedge clk) disable iff (rst)
      ((st_q == SQ_WAIT) && !(|(eng_done & cur_q))) |=> (eng_start == '0));
   // R3: operand stays put during the wait
   a_r3_arg_stable: assert property (@(posedge clk) disable iff (rst)
      (st_q == SQ_WAIT) |=> ((st_q != SQ_WAIT) || $stable(eng_arg)));
   // R7: unused opcode flagged and not started
   a_r7_bad_flag: assert property (@(posedge clk) disable iff (rst)
      ((st_q == SQ_IDLE) && head_valid && !op_ok) |=> (bad_opc && eng_start == '0));
   // R7: flag is sticky
   a_r7_sticky: assert property (@(posedge clk) disable iff (rst)
      bad_opc |=> bad_opc);
endmodule

// File: rtl/cisc_issue_seq.sv
`timescale 1ns/1ps
module cisc_issue_seq #(
   parameter int unsigned WORD_W = 32,
   parameter int unsigned OPC_W  = 3,
   parameter int unsigned ARG_W  = 16,
   parameter int unsigned N_ENG  = 5,
   parameter int unsigned DEPTH  = 16
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_valid,
   input  logic [WORD_W-1:0] wr_data,
   output logic              wr_ready,
   output logic [N_ENG-1:0]  eng_start,
   output logic [ARG_W-1:0]  eng_arg,
   input  logic [N_ENG-1:0]  eng_done,
   output logic              busy,
   output logic              bad_opc
);
   localparam int unsigned KEEP_W = OPC_W + ARG_W;

   if (KEEP_W >= WORD_W) begin : g_bad_word
      $error("cisc_issue_seq: opcode and operand must leave reserved bits");
   end

   logic [KEEP_W-1:0] head;
   logic              empty, full, pop;
   logic [N_ENG-1:0]  sel;
   logic              op_ok;
   logic [ARG_W-1:0]  arg;
   logic              in_flight;
   logic              unused_resv;

   assign unused_resv = ^wr_data[WORD_W-1:KEEP_W];

   cseq_fifo #(.W(KEEP_W), .DEPTH(DEPTH)) u_fifo (
      .clk   (clk),
      .rst   (rst),
      .push  (wr_valid),
      .din   (wr_data[KEEP_W-1:0]),
      .pop   (pop),
      .head  (head),
      .empty (empty),
      .full  (full)
   );

   cseq_decode #(.OPC_W(OPC_W), .ARG_W(ARG_W), .N_ENG(N_ENG)) u_dec (
      .word  (head),
      .sel   (sel),
      .op_ok (op_ok),
      .arg   (arg)
   );

   cseq_ctrl #(.N_ENG(N_ENG), .ARG_W(ARG_W)) u_ctrl (
      .clk        (clk),
      .rst        (rst),
      .head_valid (!empty),
      .op_ok      (op_ok),
      .sel        (sel),
      .arg_in     (arg),
      .eng_done   (eng_done),
      .pop        (pop),
      .eng_start  (eng_start),
      .eng_arg    (eng_arg),
      .bad_opc    (bad_opc),
      .in_flight  (in_flight)
   );

   assign wr_ready = !full;
   assign busy     = in_flight || !empty;

   // R8: a start implies the block reports busy
   a_r8_busy_on_start: assert property (@(posedge clk) disable iff (rst)
      (|eng_start) |-> busy);
   // R9: reset leaves an empty, idle sequencer
   a_r9_reset_idle: assert property (@(posedge clk)
      rst |=> (!busy && wr_ready && eng_start == '0 && !bad_opc));
endmodule

// File: tb/cisc_issue_seq_test.sv
`timescale 1ns/1ps
module cisc_issue_seq_test;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        wr_valid = 1'b0;
   logic [31:0] wr_data = '0;
   logic        wr_ready;
   logic [4:0]  eng_start;
   logic [15:0] eng_arg;
   logic [4:0]  eng_done = '0;
   logic        busy;
   logic        bad_opc;

   always #2 clk = ~clk;

   cisc_issue_seq uut (
      .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_data(wr_data),
      .wr_ready(wr_ready), .eng_start(eng_start), .eng_arg(eng_arg),
      .eng_done(eng_done), .busy(busy), .bad_opc(bad_opc)
   );

   int checks = 0;
   int errors = 0;
   int exp_eng[$];
   int exp_arg[$];
   bit hold = 1'b0;
   bit idle_poke = 1'b0;
   bit in_flight = 1'b0;
   logic [4:0]  cur = '0;
   logic [15:0] cur_arg = '0;
   int cnt = 0;
   int seq = 0;
   int n_starts = 0;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // scoreboard monitor and engine responder
   always @(negedge clk) begin
      if (rst) begin
         in_flight = 1'b0;
         eng_done  = '0;
      end else begin
         eng_done = '0;
         if (idle_poke && !in_flight) eng_done = '1;   // R6 stray done while idle
         if (eng_start != '0) begin
            int idx;
            idx = -1;
            for (int i = 0; i < 5; i++) if (eng_start[i]) idx = i;
            n_starts++;
            chk($countones(eng_start) == 1, "R5 one engine", int'(eng_start), 1);
            chk(!in_flight, "R6 start before done", 1, 0);
            if (exp_eng.size() == 0) begin
               chk(1'b0, "R2/R7 unexpected start", int'(eng_start), 0);
            end else begin
               int ee, ea;
               ee = exp_eng.pop_front();
               ea = exp_arg.pop_front();
               chk(idx == ee, "R4 engine select", idx, ee);
               chk(int'(eng_arg) == ea, "R3 operand/order", int'(eng_arg), ea);
            end
            in_flight = 1'b1;
            cur       = eng_start;
            cur_arg   = eng_arg;
            cnt       = (seq * 5) % 9 + 1;
            seq++;
         end else if (in_flight) begin
            if (eng_arg != cur_arg) chk(1'b0, "R3 operand stable", int'(eng_arg), int'(cur_arg));
            if (!hold) begin
               if (cnt == 0) begin
                  eng_done  = cur;
                  in_flight = 1'b0;
               end else begin
                  if (cnt == 2) eng_done = (cur == 5'b10000) ? 5'b00001 : (cur << 1); // R6 stray
                  cnt--;
               end
            end
         end
      end
   end

   task automatic push_word(input int op, input int arg, input int resv, input bit expect_issue);
      wr_data  = {13'(resv), 16'(arg), 3'(op)};
      wr_valid = 1'b1;
      while (!wr_ready) @(negedge clk);
      if (expect_issue) begin
         exp_eng.push_back(op);
         exp_arg.push_back(arg);
      end
      @(negedge clk);
      wr_valid = 1'b0;
   endtask

   task automatic drain(input string req);
      int n;
      n = 0;
      while ((exp_eng.size() != 0 || in_flight || busy) && n < 3000) begin
         @(negedge clk);
         n++;
      end
      chk(n < 3000, req, n, 0);
      chk(exp_eng.size() == 0, req, exp_eng.size(), 0);
   endtask

   task automatic finish_run();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      finish_run();
   end

   initial begin
      int s0;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      // R1 reset state
      chk(wr_ready == 1'b1, "R1 wr_ready", wr_ready, 1);
      chk(busy == 1'b0, "R1 busy", busy, 0);
      chk(eng_start == '0, "R1 eng_start", eng_start, 0);
      chk(bad_opc == 1'b0, "R1 bad_opc", bad_opc, 0);

      // R4 every opcode, R3 order and operand
      for (int k = 0; k < 5; k++) push_word(k, 16'h1000 + k * 16'h0111, 0, 1'b1);
      push_word(4, 16'hFFFF, 0, 1'b1);
      push_word(0, 16'h0000, 0, 1'b1);
      drain("R4 drain");
      chk(busy == 1'b0, "R8 idle busy", busy, 0);

      // R8 busy while waiting
      hold = 1'b1;
      push_word(2, 16'h00AA, 0, 1'b1);
      repeat (3) @(negedge clk);
      chk(busy == 1'b1, "R8 busy in flight", busy, 1);
      hold = 1'b0;
      drain("R8 drain");

      // R10 reserved bits ignored
      push_word(2, 16'hBEEF, 13'h1FFF, 1'b1);
      push_word(3, 16'h0F0F, 13'h0AAA, 1'b1);
      drain("R10 drain");

      // R7 unused opcodes
      s0 = n_starts;
      push_word(1, 16'h0101, 0, 1'b1);
      push_word(5, 16'h5555, 0, 1'b0);
      push_word(3, 16'h0303, 0, 1'b1);
      push_word(6, 16'h6666, 0, 1'b0);
      push_word(7, 16'h7777, 0, 1'b0);
      push_word(0, 16'h0A0A, 0, 1'b1);
      drain("R7 drain");
      chk(bad_opc == 1'b1, "R7 bad_opc set", bad_opc, 1);
      chk(n_starts - s0 == 3, "R7 start count", n_starts - s0, 3);
      repeat (3) @(negedge clk);
      chk(bad_opc == 1'b1, "R7 sticky", bad_opc, 1);

      // R6 stray done while idle
      s0 = n_starts;
      idle_poke = 1'b1;
      repeat (4) @(negedge clk);
      idle_poke = 1'b0;
      @(negedge clk);
      chk(n_starts == s0, "R6 idle done no start", n_starts - s0, 0);
      chk(busy == 1'b0, "R6 idle done busy", busy, 0);

      // R2 full queue
      s0 = n_starts;
      hold = 1'b1;
      for (int k = 0; k < 17; k++) push_word(k % 5, 16'h2000 + k, 0, 1'b1);
      repeat (2) @(negedge clk);
      chk(wr_ready == 1'b0, "R2 ready low when full", wr_ready, 0);
      chk(busy == 1'b1, "R8 busy when full", busy, 1);
      wr_data  = {13'd0, 16'h1234, 3'd4};
      wr_valid = 1'b1;
      repeat (3) begin
         @(negedge clk);
         chk(wr_ready == 1'b0, "R2 ready stays low", wr_ready, 0);
      end
      wr_valid = 1'b0;
      hold = 1'b0;
      drain("R2 drain");
      chk(n_starts - s0 == 17, "R2 refused word dropped", n_starts - s0, 17);

      // R9 reset mid-flight
      hold = 1'b1;
      push_word(1, 16'h0909, 0, 1'b1);
      push_word(2, 16'h0A0A, 0, 1'b1);
      push_word(3, 16'h0B0B, 0, 1'b1);
      @(negedge clk);
      rst = 1'b1;
      exp_eng.delete();
      exp_arg.delete();
      repeat (2) @(negedge clk);
      rst = 1'b0;
      hold = 1'b0;
      @(negedge clk);
      chk(wr_ready == 1'b1, "R9 ready", wr_ready, 1);
      chk(busy == 1'b0, "R9 busy", busy, 0);
      chk(eng_start == '0, "R9 start", eng_start, 0);
      chk(bad_opc == 1'b0, "R9 bad_opc cleared", bad_opc, 0);
      s0 = n_starts;
      push_word(3, 16'h0777, 0, 1'b1);
      drain("R9 drain");
      chk(n_starts - s0 == 1, "R9 no stale issue", n_starts - s0, 1);

      finish_run();
   end
endmodule